// File: doc/BRIEF.md
# Dimmable Fluorescent Display Segment Driver

This block turns a BCD clock time (hours 1 to 12, minutes 00 to 59) and a colon flag into the 22 active-high segment enables of a three-and-a-half digit fluorescent clock display. The leading hour position is a single line that lights the "1" strokes (segments b and c). The hour-ones and minute-ones positions have full seven-segment lines. The minute-tens position shares one line for segments a and d, because those two segments agree for every value from 0 to 5. One further line carries the colon.

All segments are modulated by a brightness duty chosen by two dimmer selects. The duty runs on a 16-slot frame that advances on a 1024 Hz time-base strobe. A display-enable input forces every segment off while it is low. The dimmer selects and the display enable are asynchronous and pass through two-flop synchronisers. A duty change is taken up only when a new frame begins, so a partial frame never produces a short pulse. The high-voltage output stage, the filament drive and the grid drive belong to other blocks.

Top module: `vfd_seg_driver`

## Requirements
- R1: Bit 0 of `seg_en` is the leading "1" line (b and c together). It is on exactly when `hr_tens` is 1, which is the case for hours 10, 11 and 12.
- R2: Bits 7:1 carry the hour-ones digit and bits 20:14 carry the minute-ones digit, with segment a in the lowest bit through segment g in the highest bit. The patterns are the standard ones: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=abcdefg, 9=abcdfg. A digit value of 10 to 15 leaves its seven bits off.
- R3: Bits 13:8 carry the minute-tens digit in the order shared-a/d, b, c, e, f, g, using the same patterns as R2. The shared line is on for 0, 2, 3 and 5. The values 6 and 7 leave all six bits off.
- R4: Bit 21 is the colon and follows `colon_on`.
- R5: The selects {`dim_sel_a`,`dim_sel_b`} choose the number of lit slots per 16-slot frame: 11 gives 1, 01 gives 2, 10 gives 4 and 00 gives 16 (always on).
- R6: Each `tick_1024` pulse advances the slot by one, and the slot wraps from 15 to 0. Segments are shown in slots 0 to W-1 and are off in the other slots, where W is the lit-slot count from R5.
- R7: A new duty takes effect only at the first slot of a frame. It is captured on the tick that wraps slot 15 to slot 0, and the rest of the current frame keeps the old duty.
- R8: While `disp_en` is low, all 22 outputs are 0. The selects and `disp_en` pass through two synchronising flops, and `seg_en` is registered, so a change of `disp_en` shows at the output on the third clock edge.
- R9: While reset is held and just after it, `seg_en` is 0, the slot is 0 and the duty is 16 of 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1024 | input | 1 | One-cycle strobe at 1024 Hz that advances the PWM slot |
| hr_tens | input | 1 | Hour tens digit (0 or 1) |
| hr_ones | input | 4 | Hour ones digit, BCD |
| min_tens | input | 3 | Minute tens digit, 0 to 5 |
| min_ones | input | 4 | Minute ones digit, BCD |
| colon_on | input | 1 | Colon segment request |
| dim_sel_a | input | 1 | First brightness select, asynchronous |
| dim_sel_b | input | 1 | Second brightness select, asynchronous |
| disp_en | input | 1 | Display enable, asynchronous; low blanks every segment |
| seg_en | output | 22 | Active-high segment enables |

## Verification
The bench steps whole PWM frames slot by slot for each of the four duty codes. A swapped duty code, or a comparison off by one, would light the wrong number of slots. It changes the selects in the middle of a frame and checks that the remaining slots keep the old duty; a design that applied the change at once would light slots that should stay dark. It drives every digit value, including the minute-tens values 1 and 4 where the shared a/d line must stay off and the out-of-range codes that must blank. It also drops `disp_en` while the display is lit at full duty, where a design that ignored it, or that skipped the synchroniser, would show the fault in the output cycle or the output value.

// File: rtl/vfd_seg_pkg.sv
`timescale 1ns/1ps
// Shared constants and the seven-segment table for the segment driver.
// Assumes segment a is bit 0 and segment g is bit 6 of a pattern.
package vfd_seg_pkg;

    localparam int NUM_SEG = 22;

    // Bit positions of each display group inside seg_en
    localparam int LEAD_BIT  = 0;
    localparam int HR1_LSB   = 1;
    localparam int MT_LSB    = 8;
    localparam int MO_LSB    = 14;
    localparam int COLON_BIT = 21;

    // Return the standard a..g pattern, or all off for a value that is not a decimal digit
    function automatic logic [6:0] digit_pattern(input logic [3:0] v);
        case (v)
            4'd0: digit_pattern = 7'h3F;
            4'd1: digit_pattern = 7'h06;
            4'd2: digit_pattern = 7'h5B;
            4'd3: digit_pattern = 7'h4F;
            4'd4: digit_pattern = 7'h66;
            4'd5: digit_pattern = 7'h6D;
            4'd6: digit_pattern = 7'h7D;
            4'd7: digit_pattern = 7'h07;
            4'd8: digit_pattern = 7'h7F;
            4'd9: digit_pattern = 7'h6F;
            default: digit_pattern = 7'h00;
        endcase
    endfunction

endpackage

// File: rtl/vfd_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a bundle of asynchronous level inputs.
// Assumes the inputs are slow levels, so each bit may be synchronised on its own.
module vfd_sync #(
    parameter int            W       = 3,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [STAGES-1:0][W-1:0] pipe;

    // Shift the raw levels through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {STAGES{RST_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d_async};
    end

    assign q_sync = pipe[STAGES-1];

endmodule

// File: rtl/vfd_pwm.sv
`timescale 1ns/1ps
// Brightness frame generator. It counts SLOTS slots, one per time-base tick, and
// raises lit_slot in the first W slots, where W comes from the dimmer selects.
// The selects must already be synchronous. W is reloaded only on the tick that
// wraps the frame. SLOTS must be a multiple of 16.
module vfd_pwm #(
    parameter int SLOTS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic sel_a,
    input  logic sel_b,
    output logic lit_slot
);

    localparam int SLOT_W = $clog2(SLOTS);
    localparam int WID_W  = SLOT_W + 1;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0] slot;
    logic [WID_W-1:0]  lit_width;
    logic [WID_W-1:0]  req_width;
    logic              frame_wrap;

    // Map the select code to a lit-slot count
    always_comb begin
        case ({sel_a, sel_b})
            2'b11:   req_width = WID_W'(SLOTS / 16);
            2'b01:   req_width = WID_W'(SLOTS / 8);
            2'b10:   req_width = WID_W'(SLOTS / 4);
            default: req_width = WID_W'(SLOTS);
        endcase
    end

    assign frame_wrap = tick && (slot == LAST_SLOT);

    // Advance the slot on every tick and wrap at the end of the frame
    always_ff @(posedge clk) begin
        if (!rst_n)    slot <= '0;
        else if (tick) slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
    end

    // Take up a new duty only when the frame wraps
    always_ff @(posedge clk) begin
        if (!rst_n)          lit_width <= WID_W'(SLOTS);
        else if (frame_wrap) lit_width <= req_width;
    end

    assign lit_slot = ({1'b0, slot} < lit_width);

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(slot)); // R6
    AST_DUTY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wrap |=> $stable(lit_width)); // R7
    AST_WIDTH_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lit_width) == 1); // R5
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wrap |=> (slot == '0)); // R6

endmodule

// File: rtl/vfd_digit_map.sv
`timescale 1ns/1ps
// Maps the BCD time digits and the colon flag onto the 22-line segment layout.
// Purely combinational. Assumes min_tens holds 0..5; the values 6 and 7 are blanked.
module vfd_digit_map
    import vfd_seg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hr_tens,
    input  logic [3:0]         hr_ones,
    input  logic [2:0]         min_tens,
    input  logic [3:0]         min_ones,
    input  logic               colon_on,
    output logic [NUM_SEG-1:0] pattern
);

    logic [6:0] hr1_pat;
    logic [6:0] mt_pat;
    logic [6:0] mo_pat;

    // Decode each digit position
    always_comb begin
        hr1_pat = digit_pattern(hr_ones);
        mo_pat  = digit_pattern(min_ones);
        mt_pat  = (min_tens <= 3'd5) ? digit_pattern({1'b0, min_tens}) : 7'h00;
    end

    // Place the groups into the output vector; the minute-tens digit drops its separate d line
    always_comb begin
        pattern                       = '0;
        pattern[LEAD_BIT]             = hr_tens;
        pattern[HR1_LSB +: 7]         = hr1_pat;
        pattern[MT_LSB]               = mt_pat[0];
        pattern[MT_LSB+1 +: 2]        = mt_pat[2:1];
        pattern[MT_LSB+3 +: 3]        = mt_pat[6:4];
        pattern[MO_LSB +: 7]          = mo_pat;
        pattern[COLON_BIT]            = colon_on;
    end

    AST_AD_TIED: assert property (@(posedge clk) disable iff (!rst_n)
        mt_pat[0] == mt_pat[3]); // R3

endmodule

// File: rtl/vfd_seg_driver.sv
`timescale 1ns/1ps
// Top of the dimmable fluorescent display segment driver. It synchronises the
// dimmer selects and the display enable, gates the decoded digit pattern with
// the brightness frame, and registers the 22 active-high segment enables.
// Assumes tick_1024 is a one-cycle strobe in the clk domain.
module vfd_seg_driver
    import vfd_seg_pkg::*;
#(
    parameter int SLOTS       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_1024,
    input  logic               hr_tens,
    input  logic [3:0]         hr_ones,
    input  logic [2:0]         min_tens,
    input  logic [3:0]         min_ones,
    input  logic               colon_on,
    input  logic               dim_sel_a,
    input  logic               dim_sel_b,
    input  logic               disp_en,
    output logic [NUM_SEG-1:0] seg_en
);

    logic [2:0]         ctl_sync;
    logic               en_s;
    logic               sel_a_s;
    logic               sel_b_s;
    logic               lit_slot;
    logic [NUM_SEG-1:0] pattern;

    vfd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({disp_en, dim_sel_a, dim_sel_b}),
        .q_sync  (ctl_sync)
    );

    assign {en_s, sel_a_s, sel_b_s} = ctl_sync;

    vfd_pwm #(.SLOTS(SLOTS)) u_pwm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1024),
        .sel_a    (sel_a_s),
        .sel_b    (sel_b_s),
        .lit_slot (lit_slot)
    );

    vfd_digit_map u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .hr_tens  (hr_tens),
        .hr_ones  (hr_ones),
        .min_tens (min_tens),
        .min_ones (min_ones),
        .colon_on (colon_on),
        .pattern  (pattern)
    );

    // Register the gated pattern as the segment outputs
    always_ff @(posedge clk) begin
        if (!rst_n)                 seg_en <= '0;
        else if (en_s && lit_slot)  seg_en <= pattern;
        else                        seg_en <= '0;
    end

    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> (seg_en == '0)); // R8
    AST_LEAD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !hr_tens |=> !seg_en[LEAD_BIT]); // R1
    AST_COLON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !colon_on |=> !seg_en[COLON_BIT]); // R4
    AST_MT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (min_tens > 3'd5) |=> (seg_en[MT_LSB +: 6] == '0)); // R3

endmodule

// File: tb/sim_vfd_seg_driver.sv
`timescale 1ns/1ps
module sim_vfd_seg_driver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1024 = 1'b0;
    logic        hr_tens = 1'b0;
    logic [3:0]  hr_ones = 4'd0;
    logic [2:0]  min_tens = 3'd0;
    logic [3:0]  min_ones = 4'd0;
    logic        colon_on = 1'b0;
    logic        dim_sel_a = 1'b0;
    logic        dim_sel_b = 1'b0;
    logic        disp_en = 1'b0;
    logic [21:0] seg_en;

    int n_checks = 0;
    int n_fail   = 0;
    int bslot    = 0;

    vfd_seg_driver u0 (
        .clk(clk), .rst_n(rst_n), .tick_1024(tick_1024),
        .hr_tens(hr_tens), .hr_ones(hr_ones), .min_tens(min_tens),
        .min_ones(min_ones), .colon_on(colon_on), .dim_sel_a(dim_sel_a),
        .dim_sel_b(dim_sel_b), .disp_en(disp_en), .seg_en(seg_en)
    );

    always #10 clk = ~clk;

    // Standard a..g patterns from R2, bit 0 = a
    function automatic logic [6:0] ref_digit(input int v);
        case (v)
            0: return 7'b0111111;
            1: return 7'b0000110;
            2: return 7'b1011011;
            3: return 7'b1001111;
            4: return 7'b1100110;
            5: return 7'b1101101;
            6: return 7'b1111101;
            7: return 7'b0000111;
            8: return 7'b1111111;
            9: return 7'b1101111;
            default: return 7'b0000000;
        endcase
    endfunction

    function automatic logic [21:0] ref_vec(input int ht, input int ho, input int mt,
                                            input int mo, input logic col);
        logic [21:0] v;
        logic [6:0]  t;
        v = '0;
        v[0] = (ht == 1);
        v[7:1] = ref_digit(ho);
        t = (mt <= 5) ? ref_digit(mt) : 7'b0;
        v[13:8] = {t[6], t[5], t[4], t[2], t[1], t[0]};
        v[20:14] = ref_digit(mo);
        v[21] = col;
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [21:0] act,
                         input logic [21:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%06h expected=%06h", tag, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_tick();
        @(negedge clk) tick_1024 = 1'b1;
        @(negedge clk) tick_1024 = 1'b0;
        bslot = (bslot + 1) % 16;
    endtask

    task automatic set_time(input int ht, input int ho, input int mt, input int mo,
                            input logic col);
        hr_tens = ht[0]; hr_ones = ho[3:0]; min_tens = mt[2:0];
        min_ones = mo[3:0]; colon_on = col;
    endtask

    // Set selects, let them synchronise, then run ticks until a frame wrap loads them
    task automatic load_duty(input logic a, input logic b);
        dim_sel_a = a; dim_sel_b = b;
        clocks(4);
        do begin
            do_tick();
        end while (bslot != 0);
    endtask

    // Walk one frame from slot 0 and check lit/dark per slot
    task automatic walk_frame(input int width, input string tag);
        logic [21:0] e;
        e = ref_vec(1, 2, 3, 4, 1'b1);
        for (int s = 0; s < 16; s++) begin
            clocks(2);
            if (s < width) check(seg_en == e, tag, seg_en, e);
            else           check(seg_en == 22'd0, tag, seg_en, 22'd0);
            do_tick();
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        disp_en = 1'b1;
        set_time(1, 2, 3, 4, 1'b1);
        clocks(4);
        check(seg_en == 22'd0, "R9 reset output", seg_en, 22'd0);
        rst_n = 1'b1;
        bslot = 0;
        clocks(4);
        // default duty is full: lit at slot 0
        check(seg_en == ref_vec(1, 2, 3, 4, 1'b1), "R9 full duty after reset",
              seg_en, ref_vec(1, 2, 3, 4, 1'b1));
    endtask

    task automatic t_digits();
        int ht[8] = '{1, 1, 0, 0, 1, 0, 0, 1};
        int ho[8] = '{2, 0, 1, 9, 1, 8, 6, 0};
        int mt[8] = '{0, 5, 0, 3, 2, 1, 4, 6};
        int mo[8] = '{0, 9, 7, 4, 5, 6, 3, 12};
        for (int i = 0; i < 8; i++) begin
            logic [21:0] e;
            set_time(ht[i], ho[i], mt[i], mo[i], i[0]);
            e = ref_vec(ht[i], ho[i], mt[i], mo[i], i[0]);
            clocks(2);
            check(seg_en == e, "R1 R2 R3 R4 digit map", seg_en, e);
        end
        // shared a/d line off for minute tens 1 and 4
        set_time(0, 5, 1, 0, 1'b0); clocks(2);
        check(seg_en[8] == 1'b0, "R3 ad off for 1", seg_en, ref_vec(0, 5, 1, 0, 1'b0));
        set_time(0, 5, 4, 0, 1'b0); clocks(2);
        check(seg_en[8] == 1'b0, "R3 ad off for 4", seg_en, ref_vec(0, 5, 4, 0, 1'b0));
        set_time(0, 15, 7, 10, 1'b0); clocks(2);
        check(seg_en == 22'd0, "R2 R3 out-of-range blank", seg_en, 22'd0);
        set_time(1, 2, 3, 4, 1'b1);
    endtask

    task automatic t_duty();
        load_duty(1'b0, 1'b0); walk_frame(16, "R5 R6 duty 16/16");
        load_duty(1'b1, 1'b0); walk_frame(4,  "R5 R6 duty 4/16");
        load_duty(1'b0, 1'b1); walk_frame(2,  "R5 R6 duty 2/16");
        load_duty(1'b1, 1'b1); walk_frame(1,  "R5 R6 duty 1/16");
    endtask

    task automatic t_midframe();
        logic [21:0] e;
        e = ref_vec(1, 2, 3, 4, 1'b1);
        // duty 1/16 is active, bench at slot 0
        do_tick();
        dim_sel_a = 1'b0; dim_sel_b = 1'b0;
        clocks(4);
        while (bslot != 0) begin
            clocks(2);
            check(seg_en == 22'd0, "R7 old duty kept mid-frame", seg_en, 22'd0);
            do_tick();
        end
        for (int s = 0; s < 16; s++) begin
            clocks(2);
            check(seg_en == e, "R7 new duty after wrap", seg_en, e);
            do_tick();
        end
    endtask

    task automatic t_blank();
        logic [21:0] e;
        e = ref_vec(1, 2, 3, 4, 1'b1);
        @(negedge clk) disp_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(seg_en == e, "R8 still lit before third edge", seg_en, e);
        @(negedge clk);
        check(seg_en == 22'd0, "R8 dark at third edge", seg_en, 22'd0);
        set_time(0, 8, 5, 8, 1'b1);
        clocks(3);
        check(seg_en == 22'd0, "R8 stays dark", seg_en, 22'd0);
        set_time(1, 2, 3, 4, 1'b1);
        disp_en = 1'b1;
        clocks(4);
        check(seg_en == e, "R8 relit", seg_en, e);
    endtask

    initial begin
        t_reset();
        t_digits();
        t_blank();
        t_duty();
        t_midframe();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #3000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%06h expected=%06h", seg_en, 22'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule